// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Port

This block is the digital front end of a two-channel voltage DAC. A host drives three serial lines: an active-low load/select strobe, a serial clock and a data line. While the strobe is low the block samples one data bit per serial clock rising edge into a frame register. When the strobe returns high, the block decodes the last 24 bits received and carries out the command.

Each channel has a two-stage register pair. The input stage holds a staged code. The active stage holds the code that is presented to the converter. Writes and updates can be issued separately, or combined in one frame. The target can be channel A, channel B or both channels.

The three serial lines are brought into the system clock domain through two-flop synchronisers, and their edges are detected in that domain. Every executed update also emits a one-cycle pulse that carries a channel mask, so that a neighbouring power controller can wake the channels it names. The code width is set by a parameter and may be 12, 10 or 8 bits. A second parameter chooses whether reset loads zero-scale or mid-scale.

Top module: `dac_cmd_port`

## Requirements
- R1: During and after reset, both active codes and both staged codes equal zero when RST_MID=0, and equal 2^(RES-1) when RST_MID=1. The update pulse is low during and after reset.
- R2: A bit is taken only on a serial clock rising edge while the select line is low. The serial clock level at the moment select falls makes no difference. Clock edges seen while select is high are ignored.
- R3: A 24-bit frame is received MSB first and laid out as follows:
  - bits 23..20 hold the operation;
  - bits 19..16 hold the channel selector;
  - the code sits left-justified in bits 15..(16-RES);
  - the low 16-RES bits are don't-care.
- R4: In a 32-bit frame, the first 8 bits received are ignored and the last 24 bits are decoded as in R3.
- R5: A frame whose bit count at the select rising edge is neither 24 nor 32 changes no register and produces no update pulse.
- R6: Operation 0000 loads the code into the staged register of each selected channel and leaves the active codes unchanged.
- R7: Operation 0001 copies the staged register into the active register of each selected channel. The code field of the frame is ignored.
- R8: Operation 0010 loads the code into the staged register of each selected channel, then copies the staged registers of both channels into their active registers.
- R9: Operation 0011 loads the code into both the staged and the active register of each selected channel.
- R10: Selector 0000 picks channel A, 0001 picks channel B and 1111 picks both channels. Operation 1111, any other operation code and any other selector code change no register and produce no pulse.
- R11: Each executed 0001, 0010 or 0011 frame produces exactly one single-cycle update pulse. Its mask has bit 0 for channel A and bit 1 for channel B, and names the channels whose active register was loaded. Operation 0000 produces no pulse.
- R12: No register changes while select is still low, even after a complete frame has been shifted in. Execution happens only after the select rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_n_i | input | 1 | Active-low select; its rising edge executes the frame |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sdat_i | input | 1 | Serial data, MSB first |
| chan_a_code_o | output | RES | Active code of channel A |
| chan_b_code_o | output | RES | Active code of channel B |
| upd_pulse_o | output | 1 | One-cycle pulse per executed update |
| upd_chan_o | output | 2 | Channel mask that goes with the update pulse |

## Verification
The assertions assume that each serial clock phase and each select level lasts at least two system clock cycles, so that no edge is lost in the synchronisers. They also assume that select stays high for more than one synchronised cycle after it rises. The stimulus holds every serial phase for four system clocks and keeps select high for about a dozen clocks between frames. Random frames mix the following:
- every operation and selector code, reserved ones included;
- lengths of 24 and 32 bits, plus wrong lengths just around them;
- both serial clock idle levels;
- stray clock pulses while select is high.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int NCH = 2;

  localparam logic [3:0] OP_WRITE          = 4'h0;
  localparam logic [3:0] OP_LOAD           = 4'h1;
  localparam logic [3:0] OP_WRITE_LOAD_ALL = 4'h2;
  localparam logic [3:0] OP_WRITE_LOAD     = 4'h3;
  localparam logic [3:0] OP_IDLE           = 4'hF;

  localparam logic [3:0] SEL_A   = 4'h0;
  localparam logic [3:0] SEL_B   = 4'h1;
  localparam logic [3:0] SEL_ALL = 4'hF;

  function automatic logic [NCH-1:0] sel_mask(logic [3:0] sel);
    case (sel)
      SEL_A:   sel_mask = 2'b01;
      SEL_B:   sel_mask = 2'b10;
      SEL_ALL: sel_mask = 2'b11;
      default: sel_mask = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/dcp_sync.sv
module dcp_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dcp_shifter.sv
module dcp_shifter #(
  parameter int RES   = 12,
  parameter int FRM_W = 24,
  parameter int EXT_W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_s_i,
  input  logic           sck_s_i,
  input  logic           sdi_s_i,
  output logic           frm_stb_o,
  output logic [3:0]     op_o,
  output logic [3:0]     sel_o,
  output logic [RES-1:0] code_o
);
  localparam int CNT_W    = $clog2(EXT_W + 2);
  localparam int OP_MSB   = FRM_W - 1;
  localparam int SEL_MSB  = FRM_W - 5;
  localparam int DATA_MSB = FRM_W - 9;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             cs_d_q, sck_d_q;
  logic [FRM_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stb_q, stb_d;
  logic [3:0]       op_q, op_d, sel_q, sel_d;
  logic [RES-1:0]   code_q, code_d;
  logic             sck_rise, cs_rise, shift_en, len_ok, take;

  always_comb begin
    sck_rise = sck_s_i & ~sck_d_q;
    cs_rise  = cs_s_i & ~cs_d_q;
    shift_en = sck_rise & ~cs_s_i;
    len_ok   = (cnt_q == CNT_W'(FRM_W)) || (cnt_q == CNT_W'(EXT_W));
    take     = cs_rise & len_ok;

    sreg_d = shift_en ? {sreg_q[FRM_W-2:0], sdi_s_i} : sreg_q;

    if (cs_s_i)                              cnt_d = '0;
    else if (shift_en && cnt_q != CNT_MAX)   cnt_d = cnt_q + 1'b1;
    else                                     cnt_d = cnt_q;

    stb_d  = take;
    op_d   = take ? sreg_q[OP_MSB -: 4]     : op_q;
    sel_d  = take ? sreg_q[SEL_MSB -: 4]    : sel_q;
    code_d = take ? sreg_q[DATA_MSB -: RES] : code_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
      sreg_q  <= '0;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
      op_q    <= dcp_pkg::OP_IDLE;
      sel_q   <= '0;
      code_q  <= '0;
    end else begin
      cs_d_q  <= cs_s_i;
      sck_d_q <= sck_s_i;
      sreg_q  <= sreg_d;
      cnt_q   <= cnt_d;
      stb_q   <= stb_d;
      op_q    <= op_d;
      sel_q   <= sel_d;
      code_q  <= code_d;
    end
  end

  assign frm_stb_o = stb_q;
  assign op_o      = op_q;
  assign sel_o     = sel_q;
  assign code_o    = code_q;

  // R2: while select stays high no bit is counted
  a_r2_idle_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && $past(cs_s_i)) |-> (cnt_q == '0));
  // R12: a frame is released only once select is seen high
  a_r12_exec_after_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> cs_s_i);
  // R11: frame strobe never lasts two cycles
  a_r11_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
endmodule

// File: rtl/dcp_regbank.sv
module dcp_regbank #(
  parameter int   RES     = 12,
  parameter logic RST_MID = 1'b1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             frm_stb_i,
  input  logic [3:0]                       op_i,
  input  logic [3:0]                       sel_i,
  input  logic [RES-1:0]                   code_i,
  output logic [dcp_pkg::NCH-1:0][RES-1:0] act_o,
  output logic                             upd_o,
  output logic [dcp_pkg::NCH-1:0]          upd_mask_o
);
  import dcp_pkg::*;

  localparam logic [RES-1:0] RST_CODE = RST_MID ? {1'b1, {(RES-1){1'b0}}} : '0;

  logic [NCH-1:0][RES-1:0] inr_q, inr_d, act_q, act_d;
  logic                    upd_q, upd_d;
  logic [NCH-1:0]          mask_q, mask_d, m;

  always_comb begin
    inr_d  = inr_q;
    act_d  = act_q;
    upd_d  = 1'b0;
    mask_d = '0;
    m      = sel_mask(sel_i);
    if (frm_stb_i && m != '0) begin
      case (op_i)
        OP_WRITE: begin
          for (int c = 0; c < NCH; c++) if (m[c]) inr_d[c] = code_i;
        end
        OP_LOAD: begin
          for (int c = 0; c < NCH; c++) if (m[c]) act_d[c] = inr_q[c];
          upd_d  = 1'b1;
          mask_d = m;
        end
        OP_WRITE_LOAD_ALL: begin
          for (int c = 0; c < NCH; c++) if (m[c]) inr_d[c] = code_i;
          act_d  = inr_d;
          upd_d  = 1'b1;
          mask_d = '1;
        end
        OP_WRITE_LOAD: begin
          for (int c = 0; c < NCH; c++) begin
            if (m[c]) begin
              inr_d[c] = code_i;
              act_d[c] = code_i;
            end
          end
          upd_d  = 1'b1;
          mask_d = m;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inr_q  <= {NCH{RST_CODE}};
      act_q  <= {NCH{RST_CODE}};
      upd_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      inr_q  <= inr_d;
      act_q  <= act_d;
      upd_q  <= upd_d;
      mask_q <= mask_d;
    end
  end

  assign act_o      = act_q;
  assign upd_o      = upd_q;
  assign upd_mask_o = mask_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R11: an active code only moves together with a pulse naming its channel
    a_r11_act_needs_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q[c] != $past(act_q[c])) |-> (upd_q && mask_q[c]));
    // R12: staged codes only move right after a decoded frame
    a_r12_inr_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inr_q[c] != $past(inr_q[c])) |-> $past(frm_stb_i));
  end
  // R11: a pulse always names at least one channel
  a_r11_mask_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (mask_q != '0));
  // R11: pulse lasts one cycle
  a_r11_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);
endmodule

// File: rtl/dac_cmd_port.sv
module dac_cmd_port #(
  parameter int   RES     = 12,
  parameter logic RST_MID = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_n_i,
  input  logic           sclk_i,
  input  logic           sdat_i,
  output logic [RES-1:0] chan_a_code_o,
  output logic [RES-1:0] chan_b_code_o,
  output logic           upd_pulse_o,
  output logic [1:0]     upd_chan_o
);
  logic                                rst_n_s;
  logic [2:0]                          pins_s;
  logic                                frm_stb;
  logic [3:0]                          op, sel;
  logic [RES-1:0]                      code;
  logic [dcp_pkg::NCH-1:0][RES-1:0]    act;

  dcp_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_n_s));

  dcp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_n_s), .d_i({sdat_i, sclk_i, ld_n_i}), .q_o(pins_s));

  dcp_shifter #(.RES(RES)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_n_s),
    .cs_s_i(pins_s[0]), .sck_s_i(pins_s[1]), .sdi_s_i(pins_s[2]),
    .frm_stb_o(frm_stb), .op_o(op), .sel_o(sel), .code_o(code));

  dcp_regbank #(.RES(RES), .RST_MID(RST_MID)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n_s),
    .frm_stb_i(frm_stb), .op_i(op), .sel_i(sel), .code_i(code),
    .act_o(act), .upd_o(upd_pulse_o), .upd_mask_o(upd_chan_o));

  assign chan_a_code_o = act[0];
  assign chan_b_code_o = act[1];
endmodule

// File: tb/sim_dac_cmd_port.sv
`timescale 1ns/1ps
module sim_dac_cmd_port;
  localparam int   RES     = 12;
  localparam logic RST_MID = 1'b1;
  localparam logic [RES-1:0] RCODE = RST_MID ? (1 << (RES-1)) : 0;

  logic clk = 1'b0, rst_n = 1'b0, ld_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic [RES-1:0] code_a, code_b;
  logic upd;
  logic [1:0] upd_ch;

  always #4 clk = ~clk;

  dac_cmd_port #(.RES(RES), .RST_MID(RST_MID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ld_n_i(ld_n), .sclk_i(sclk), .sdat_i(sdat),
    .chan_a_code_o(code_a), .chan_b_code_o(code_b),
    .upd_pulse_o(upd), .upd_chan_o(upd_ch));

  int n_chk = 0, n_bad = 0, n_pulse = 0;
  logic [1:0] last_mask = 2'b00;
  logic done = 1'b0;
  logic [RES-1:0] m_inr [2];
  logic [RES-1:0] m_act [2];

  always @(negedge clk) if (upd) begin n_pulse++; last_mask = upd_ch; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] mask_of(logic [3:0] s);
    if (s == 4'h0) return 2'b01;
    if (s == 4'h1) return 2'b10;
    if (s == 4'hF) return 2'b11;
    return 2'b00;
  endfunction

  // model: returns expected pulse mask (0 = no pulse)
  function automatic logic [1:0] apply(logic [3:0] op, logic [3:0] s, logic [RES-1:0] c);
    logic [1:0] m = mask_of(s);
    if (m == 2'b00) return 2'b00;
    case (op)
      4'h0: begin for (int i = 0; i < 2; i++) if (m[i]) m_inr[i] = c; return 2'b00; end
      4'h1: begin for (int i = 0; i < 2; i++) if (m[i]) m_act[i] = m_inr[i]; return m; end
      4'h2: begin
        for (int i = 0; i < 2; i++) if (m[i]) m_inr[i] = c;
        for (int i = 0; i < 2; i++) m_act[i] = m_inr[i];
        return 2'b11;
      end
      4'h3: begin for (int i = 0; i < 2; i++) if (m[i]) begin m_inr[i] = c; m_act[i] = c; end return m; end
      default: return 2'b00;
    endcase
  endfunction

  task automatic clks(int n); repeat (n) @(negedge clk); endtask

  task automatic frame(int nbits, logic [3:0] op, logic [3:0] s, logic [RES-1:0] c,
                       logic sck_hi, int stray, string tag);
    logic [63:0] bits;
    logic [15:0] data;
    logic [1:0]  em;
    int          p0;
    data = 16'(c) << (16 - RES);
    data = data | (16'($urandom) & ((16'd1 << (16 - RES)) - 16'd1));
    bits = {$urandom, 8'($urandom), op, s, data};
    for (int k = 0; k < stray; k++) begin
      sdat = 1'($urandom); sclk = 1'b1; clks(4); sclk = 1'b0; clks(4);
    end
    sclk = sck_hi; clks(4);
    ld_n = 1'b0; clks(4);
    sclk = 1'b0; clks(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdat = bits[i]; clks(4); sclk = 1'b1; clks(4); sclk = 1'b0;
    end
    p0 = n_pulse;
    clks(12);
    chk("R12 a before load", 32'(code_a), 32'(m_act[0]));
    chk("R12 b before load", 32'(code_b), 32'(m_act[1]));
    chk("R12 no pulse before load", 32'(n_pulse), 32'(p0));
    ld_n = 1'b1;
    em = (nbits == 24 || nbits == 32) ? apply(op, s, c) : 2'b00;
    clks(12);
    chk({tag, " chan a"}, 32'(code_a), 32'(m_act[0]));
    chk({tag, " chan b"}, 32'(code_b), 32'(m_act[1]));
    chk({tag, " R11 pulse count"}, 32'(n_pulse - p0), (em != 0) ? 32'd1 : 32'd0);
    if (em != 0) chk({tag, " R11 pulse mask"}, 32'(last_mask), 32'(em));
  endtask

  initial begin
    int lens [7] = '{24, 32, 23, 25, 31, 33, 16};
    logic [3:0] ops [9] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hF, 4'h4, 4'h7, 4'h9, 4'h2};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin m_inr[i] = RCODE; m_act[i] = RCODE; end
    clks(3);
    chk("R1 a in reset", 32'(code_a), 32'(RCODE));
    chk("R1 pulse in reset", 32'(upd), 32'd0);
    rst_n = 1'b1;
    clks(6);
    chk("R1 a after reset", 32'(code_a), 32'(RCODE));
    chk("R1 b after reset", 32'(code_b), 32'(RCODE));
    chk("R1 no pulse", 32'(n_pulse), 32'd0);
    // directed corners
    frame(24, 4'h1, 4'h0, 12'h0, 1'b0, 0, "R7 R1 staged reset copied");
    frame(24, 4'h0, 4'h0, 12'hABC, 1'b0, 0, "R6 R3 write A only");
    frame(24, 4'h1, 4'h0, 12'h123, 1'b1, 0, "R7 R2 load A, code ignored, sck high at select");
    frame(32, 4'h3, 4'h1, 12'h5A5, 1'b0, 3, "R9 R4 R2 long frame B, stray clocks");
    frame(24, 4'h0, 4'hF, 12'hFFF, 1'b0, 0, "R6 R10 write both");
    frame(24, 4'h2, 4'h0, 12'h001, 1'b1, 0, "R8 write A update all");
    frame(24, 4'h3, 4'h2, 12'h777, 1'b0, 0, "R10 reserved selector");
    frame(24, 4'hF, 4'hF, 12'h777, 1'b0, 0, "R10 idle op");
    frame(24, 4'h5, 4'hF, 12'h777, 1'b0, 0, "R10 reserved op");
    frame(23, 4'h3, 4'hF, 12'h321, 1'b0, 0, "R5 short frame");
    frame(33, 4'h3, 4'hF, 12'h321, 1'b0, 0, "R5 overlong frame");
    frame(25, 4'h3, 4'hF, 12'h321, 1'b0, 0, "R5 25-bit frame");
    frame(24, 4'h3, 4'hF, 12'h000, 1'b0, 0, "R9 R10 write-load both zero");
    // random
    for (int n = 0; n < 120; n++) begin
      int r = int'($urandom % 10);
      int len = (r < 4) ? 24 : (r < 8) ? 32 : lens[2 + int'($urandom % 5)];
      logic [3:0] op = ops[$urandom % 9];
      logic [3:0] s;
      r = int'($urandom % 8);
      s = (r < 3) ? 4'h0 : (r < 5) ? 4'h1 : (r < 7) ? 4'hF : 4'($urandom);
      frame(len, op, s, RES'($urandom), 1'($urandom), int'($urandom % 3),
            "R3 R6 R7 R8 R9 R10 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule